// File: doc/BRIEF.md
# Dual Latched Interval Timer

This block holds two 16-bit down-counters behind a byte-wide register port. The first counter reloads itself from a 16-bit reload latch. The host can fill that latch one byte at a time without disturbing the running count. The host starts the counter only by writing the counter high byte. After that start the counter runs freely: it raises its flag each time it passes below zero and then reloads from the latch.

The second counter is a one-shot. The host first stores its low byte, then writes the high byte, which loads the whole 16-bit value and starts it. It raises its flag on the first pass below zero after a start. After that it keeps counting and wrapping but does not raise the flag again. A hold input freezes this second counter. The hold input carries one bit taken from the auxiliary control register.

A count-enable input marks the cycles on which the counters step. Read data is registered and appears on `rdata` the cycle after the read strobe. Each counter also has a one-cycle flag-clear event output.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both flags are 0, both flag-clear events are 0, and all counters and latches are 0. Both timers are stopped, so count-enable cycles change nothing until a start.
- R2: A write to offset 4 or offset 6 sets only the low byte of the timer 1 reload latch. The counter does not change and the timer does not start.
- R3: A write to offset 7 sets only the high byte of the timer 1 reload latch. It does not start timer 1 and leaves the timer 1 flag unchanged.
- R4: A write to offset 5 sets the latch high byte, starts timer 1 and clears its flag. On the next cycle the counter takes the full 16-bit latch value, and this load replaces that cycle's decrement.
- R5: A read returns its byte on `rdata` one cycle after `rd_en`. Offset 4 gives the timer 1 counter low byte and clears the timer 1 flag. Offset 5 gives the counter high byte, offset 6 the latch low byte and offset 7 the latch high byte; none of these three changes the flag. Unmapped offsets read as 0.
- R6: While timer 1 runs, each count-enable cycle decrements it by one. Stepping from 0 gives 0xFFFF and sets the timer 1 flag, and the next count-enable cycle loads the latch in place of a decrement.
- R7: A write to offset 8 stores the timer 2 low byte. A write to offset 9 starts timer 2 and clears its flag. On the next cycle the counter takes the written byte as its high byte and the stored byte as its low byte.
- R8: A read of offset 8 returns the timer 2 counter low byte and clears the timer 2 flag. A read of offset 9 returns the high byte.
- R9: Timer 2 decrements on a count-enable cycle only while `t2_hold` is 0. While `t2_hold` is 1 it keeps its value.
- R10: Timer 2 sets its flag on the first step from 0 after a start, wrapping to 0xFFFF. Later wraps do not set the flag again until the next start.
- R11: `t1_clr_evt` is high for exactly the one cycle after a read of offset 4 or a write of offset 5. `t2_clr_evt` does the same for a read of offset 8 or a write of offset 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| cnt_en | input | 1 | Count-enable for this cycle |
| t2_hold | input | 1 | Auxiliary control bit 5: 1 freezes timer 2 |
| rdata | output | 8 | Registered read data |
| t1_flag | output | 1 | Timer 1 underflow flag |
| t2_flag | output | 1 | Timer 2 underflow flag |
| t1_clr_evt | output | 1 | Timer 1 flag-clear event |
| t2_clr_evt | output | 1 | Timer 2 flag-clear event |

## Verification
A lost pending reload or load appears as a counter that reads back one off, starting with the first counter read after the affected count-enable cycle. A wrong reload or arming bit appears as a flag that is early, late, missing or repeated. The bench checks the flag on the count-enable cycle where the counter passes zero and checks counts exactly. It therefore catches an off-by-one period within one reload, and it catches a one-shot flag that fires again after one full 65536-step wrap.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int OFS_W = 4;
  localparam logic [OFS_W-1:0] OFS_T1_CLO = 4'h4;
  localparam logic [OFS_W-1:0] OFS_T1_CHI = 4'h5;
  localparam logic [OFS_W-1:0] OFS_T1_LLO = 4'h6;
  localparam logic [OFS_W-1:0] OFS_T1_LHI = 4'h7;
  localparam logic [OFS_W-1:0] OFS_T2_LO  = 4'h8;
  localparam logic [OFS_W-1:0] OFS_T2_HI  = 4'h9;
endpackage

// File: rtl/dit_reload_timer.sv
module dit_reload_timer #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              wr_lat_lo,
  input  logic              wr_lat_hi,
  input  logic              wr_start,
  input  logic              rd_clr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  latch,
  output logic              flag,
  output logic              clr_evt
);
  logic             load_q;
  logic [CNT_W-1:0] load_val;
  logic             reload_q;
  logic             running;
  logic             step;
  logic             ufl;

  assign step = running && cnt_en && !load_q;
  assign ufl  = step && !reload_q && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      latch    <= '0;
      flag     <= 1'b0;
      clr_evt  <= 1'b0;
      load_q   <= 1'b0;
      load_val <= '0;
      reload_q <= 1'b0;
      running  <= 1'b0;
    end else begin
      clr_evt <= rd_clr | wr_start;
      if (wr_lat_lo) latch[BYTE_W-1:0] <= wdata;
      if (wr_lat_hi || wr_start) latch[CNT_W-1:BYTE_W] <= wdata;
      load_q <= wr_start;
      if (wr_start) begin
        load_val <= {wdata, latch[BYTE_W-1:0]};
        running  <= 1'b1;
      end
      if (load_q) begin
        count    <= load_val;
        reload_q <= 1'b0;
      end else if (step) begin
        if (reload_q) begin
          count    <= latch;
          reload_q <= 1'b0;
        end else begin
          count <= count - 1'b1;
          if (count == '0) reload_q <= 1'b1;
        end
      end
      if (wr_start)    flag <= 1'b0;
      else if (ufl)    flag <= 1'b1;
      else if (rd_clr) flag <= 1'b0;
    end
  end

  assert_start_clears_flag_R4: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> !flag);
  assert_load_replaces_step_R4: assert property (@(posedge clk) disable iff (rst)
    load_q |=> count == $past(load_val));
  assert_latch_hi_keeps_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_lat_hi && !ufl && !rd_clr && !wr_start) |=> flag == $past(flag));
  assert_underflow_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (ufl && !wr_start) |=> flag);
  assert_clear_event_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_clr || wr_start) |=> clr_evt);
endmodule

// File: rtl/dit_oneshot_timer.sv
module dit_oneshot_timer #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              hold,
  input  logic              wr_lo,
  input  logic              wr_start,
  input  logic              rd_clr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  count,
  output logic              flag,
  output logic              clr_evt
);
  logic [BYTE_W-1:0] lo_latch;
  logic              load_q;
  logic [CNT_W-1:0]  load_val;
  logic              running;
  logic              armed;
  logic              step;
  logic              ufl;

  assign step = running && cnt_en && !hold && !load_q;
  assign ufl  = step && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_latch <= '0;
      load_q   <= 1'b0;
      load_val <= '0;
      running  <= 1'b0;
      armed    <= 1'b0;
      count    <= '0;
      flag     <= 1'b0;
      clr_evt  <= 1'b0;
    end else begin
      clr_evt <= rd_clr | wr_start;
      if (wr_lo) lo_latch <= wdata;
      load_q <= wr_start;
      if (wr_start) begin
        load_val <= {wdata, lo_latch};
        running  <= 1'b1;
        armed    <= 1'b1;
      end else if (ufl) begin
        armed <= 1'b0;
      end
      if (load_q)    count <= load_val;
      else if (step) count <= count - 1'b1;
      if (wr_start)          flag <= 1'b0;
      else if (ufl && armed) flag <= 1'b1;
      else if (rd_clr)       flag <= 1'b0;
    end
  end

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> (!flag && load_q));
  assert_hold_freezes_R9: assert property (@(posedge clk) disable iff (rst)
    (hold && !load_q) |=> count == $past(count));
  assert_flag_once_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(armed));
  assert_clear_event_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_clr || wr_start) |=> clr_evt);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              cnt_en,
  input  logic              t2_hold,
  output logic [BYTE_W-1:0] rdata,
  output logic              t1_flag,
  output logic              t2_flag,
  output logic              t1_clr_evt,
  output logic              t2_clr_evt
);
  import dit_pkg::*;

  logic sel_t1_clo, sel_t1_chi, sel_t1_llo, sel_t1_lhi, sel_t2_lo, sel_t2_hi;
  logic [CNT_W-1:0] t1_count, t1_latch, t2_count;

  assign sel_t1_clo = (addr == ADDR_W'(OFS_T1_CLO));
  assign sel_t1_chi = (addr == ADDR_W'(OFS_T1_CHI));
  assign sel_t1_llo = (addr == ADDR_W'(OFS_T1_LLO));
  assign sel_t1_lhi = (addr == ADDR_W'(OFS_T1_LHI));
  assign sel_t2_lo  = (addr == ADDR_W'(OFS_T2_LO));
  assign sel_t2_hi  = (addr == ADDR_W'(OFS_T2_HI));

  dit_reload_timer #(.BYTE_W(BYTE_W)) t1_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en),
    .wr_lat_lo(wr_en && (sel_t1_clo || sel_t1_llo)),
    .wr_lat_hi(wr_en && sel_t1_lhi),
    .wr_start(wr_en && sel_t1_chi),
    .rd_clr(rd_en && sel_t1_clo),
    .wdata(wdata), .count(t1_count), .latch(t1_latch),
    .flag(t1_flag), .clr_evt(t1_clr_evt)
  );

  dit_oneshot_timer #(.BYTE_W(BYTE_W)) t2_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .hold(t2_hold),
    .wr_lo(wr_en && sel_t2_lo),
    .wr_start(wr_en && sel_t2_hi),
    .rd_clr(rd_en && sel_t2_lo),
    .wdata(wdata), .count(t2_count),
    .flag(t2_flag), .clr_evt(t2_clr_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (sel_t1_clo)      rdata <= t1_count[BYTE_W-1:0];
      else if (sel_t1_chi) rdata <= t1_count[CNT_W-1:BYTE_W];
      else if (sel_t1_llo) rdata <= t1_latch[BYTE_W-1:0];
      else if (sel_t1_lhi) rdata <= t1_latch[CNT_W-1:BYTE_W];
      else if (sel_t2_lo)  rdata <= t2_count[BYTE_W-1:0];
      else if (sel_t2_hi)  rdata <= t2_count[CNT_W-1:BYTE_W];
      else                 rdata <= '0;
    end
  end

  assert_one_select_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_t1_clo, sel_t1_chi, sel_t1_llo, sel_t1_lhi, sel_t2_lo, sel_t2_hi}));
  assert_stable_without_read_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/dual_interval_timer_tb_top.sv
module dual_interval_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, cnt_en = 1'b0, t2_hold = 1'b0;
  logic [7:0] rdata;
  logic       t1_flag, t2_flag, t1_clr_evt, t2_clr_evt;
  int checks = 0;
  int failures = 0;
  logic last_c1, last_c2;

  always #2.5 clk = ~clk;

  dual_interval_timer dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .cnt_en(cnt_en), .t2_hold(t2_hold), .rdata(rdata),
    .t1_flag(t1_flag), .t2_flag(t2_flag), .t1_clr_evt(t1_clr_evt),
    .t2_clr_evt(t2_clr_evt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    v = rdata; last_c1 = t1_clr_evt; last_c2 = t2_clr_evt;
  endtask

  task automatic rd16(input logic [3:0] lo_a, output logic [15:0] v);
    logic [7:0] h, l;
    rd(lo_a + 4'd1, h);
    rd(lo_a, l);
    v = {h, l};
  endtask

  task automatic tick(input int k);
    cnt_en = 1'b1;
    repeat (k) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (20_000_000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v8;
    logic [15:0] v16;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, stopped timers
    check("R1 t1_flag", t1_flag, 0);
    check("R1 t2_flag", t2_flag, 0);
    check("R1 clr evts", {t1_clr_evt, t2_clr_evt}, 0);
    tick(5);
    rd16(4'h6, v16); check("R1 t1 latch", v16, 0);
    rd(4'h5, v8); check("R1 t1 count hi", v8, 0);
    rd(4'h9, v8); check("R1 t2 count hi", v8, 0);
    check("R1 flags after idle counts", {t1_flag, t2_flag}, 0);

    // R5 unmapped offsets
    for (int a = 0; a < 16; a++) begin
      if (a < 4 || a > 9) begin
        rd(a[3:0], v8); check("R5 unmapped read", v8, 0);
      end
    end

    // R2/R3 latch writes do not start timer 1
    wr(4'h4, 8'h12); wr(4'h7, 8'h34);
    rd(4'h6, v8); check("R2 latch lo via 4", v8, 8'h12);
    wr(4'h6, 8'h56);
    rd16(4'h6, v16); check("R3 latch via 6/7", v16, 16'h3456);
    tick(4);
    rd(4'h5, v8); check("R3 no start count hi", v8, 0);
    check("R3 no flag", t1_flag, 0);

    // R6 sweep of timer 1
    begin
      logic [15:0] lv [7] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0007, 16'h0100, 16'hABCD};
      for (int i = 0; i < 7; i++) begin
        for (int k = 0; k < 10; k++) begin
          logic [15:0] c; logic r; logic f;
          c = lv[i]; r = 1'b0; f = 1'b0;
          for (int s = 0; s < k; s++) begin
            if (r) begin c = lv[i]; r = 1'b0; end
            else begin if (c == 0) begin r = 1'b1; f = 1'b1; end c = c - 1'b1; end
          end
          wr(4'h6, lv[i][7:0]);
          wr(4'h5, lv[i][15:8]);
          @(negedge clk);
          tick(k);
          check("R6 t1 flag", t1_flag, f);
          rd(4'h5, v8); check("R6 t1 count hi", v8, c[15:8]);
          check("R5 read 5 keeps flag", t1_flag, f);
          rd(4'h4, v8); check("R6 t1 count lo", v8, c[7:0]);
          check("R11 t1 clear event", last_c1, 1);
          check("R5 read 4 clears flag", t1_flag, 0);
        end
      end
    end

    // R3 latch hi write with flag set, R6 reload uses new latch
    wr(4'h6, 8'h00); wr(4'h5, 8'h00); @(negedge clk);
    tick(1);
    check("R6 flag at wrap", t1_flag, 1);
    wr(4'h7, 8'h55);
    check("R3 flag unchanged", t1_flag, 1);
    check("R11 no event on write 7", t1_clr_evt, 0);
    rd(4'h5, v8); check("R3 count untouched", v8, 8'hFF);
    tick(1);
    rd16(4'h4, v16); check("R6 reload from new latch", v16, 16'h5500);

    // R4 load replaces decrement
    wr(4'h6, 8'h10);
    @(negedge clk); cnt_en = 1'b1; addr = 4'h5; wdata = 8'h00; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk); cnt_en = 1'b0;
    rd16(4'h4, v16); check("R4 load in place of decrement", v16, 16'h0010);
    check("R4 flag cleared", t1_flag, 0);

    // R7/R8/R9 timer 2 sweep
    begin
      logic [15:0] tv [6] = '{16'h0000, 16'h0001, 16'h0002, 16'h0005, 16'h0300, 16'hFFFF};
      for (int h = 0; h < 2; h++) begin
        for (int i = 0; i < 6; i++) begin
          for (int k = 0; k < 7; k++) begin
            logic [15:0] c; logic f;
            c = (h == 1) ? tv[i] : tv[i] - 16'(k);
            f = (h == 0) && (k > int'(tv[i]));
            t2_hold = 1'b0;
            wr(4'h8, tv[i][7:0]);
            wr(4'h9, tv[i][15:8]);
            check("R11 t2 clear event", t2_clr_evt, 1);
            t2_hold = h[0];
            @(negedge clk);
            tick(k);
            check("R10 t2 flag", t2_flag, f);
            rd(4'h9, v8); check("R9 t2 count hi", v8, c[15:8]);
            rd(4'h8, v8); check("R8 t2 count lo", v8, c[7:0]);
            check("R8 read 8 clears flag", t2_flag, 0);
          end
        end
      end
      t2_hold = 1'b0;
    end

    // R10 no second flag after full wrap
    wr(4'h8, 8'h00); wr(4'h9, 8'h00); @(negedge clk);
    tick(1);
    check("R10 first wrap flag", t2_flag, 1);
    rd(4'h8, v8);
    check("R7 count after wrap", v8, 8'hFF);
    tick(65536);
    check("R10 no second flag", t2_flag, 0);
    rd16(4'h8, v16); check("R10 keeps counting", v16, 16'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule